// File: doc/BRIEF.md
# Card Clock Rate Divider

This block generates the clock delivered to a smart card. The reference clock can pass through at full rate or be divided by two, four or eight, and a two-bit code selects the rate. The design runs from a single fast clock at twice the reference frequency, so a full-rate output is a register that toggles on every fast edge. Each divided setting then toggles every 2, 4 or 8 fast cycles. Every output period therefore has a 50% duty cycle.

A new rate code takes effect only at a period boundary, which is the end of a low phase. The pulse in flight always finishes at its old width and the next pulse starts at its new width. The run enable is sampled at the same boundaries. The output starts with a complete high phase and stops after a complete low phase, and while stopped it stays low.

Top module: `card_clk_divider`

## Requirements
- R1: Code 2'b00 gives one eighth of the reference rate: high and low phases of 8 fast cycles each.
- R2: Code 2'b01 gives one quarter of the reference rate: high and low phases of 4 fast cycles each.
- R3: Code 2'b11 gives one half of the reference rate: high and low phases of 2 fast cycles each.
- R4: Code 2'b10 gives the full reference rate: high and low phases of 1 fast cycle each.
- R5: A rate code is captured only at the end of a low phase. A code change in the middle of a period leaves that period at the old rate, and the next high phase uses the new rate.
- R6: There are no runt pulses. Every high phase lasts exactly the half-period of its rate. Every low phase lasts at least as long as the high phase before it.
- R7: If run_en is low at the end of a low phase, the output stops and stays low. A run_en drop during a high phase lets that high phase complete. The output never rises while run_en is low.
- R8: While stopped, run_en sampled high at a clock edge raises the output at that edge, and the code present at that edge sets the rate.
- R9: Reset forces the output low and the block stopped, with the one-eighth rate loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, twice the reference frequency |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 2 | Rate code (00 eighth, 01 quarter, 11 half, 10 full) |
| run_en | input | 1 | Run enable; low parks the output low at the next boundary |
| card_clk | output | 1 | Clock to the card |

## Verification
The output is a register, so a start seen at edge k shows as a high level after edge k. The bench samples it at the falling edge that follows. A rate change shows only after the current period ends. The bench therefore waits for the next rising output before it counts high and low samples, and the code-change test counts the in-flight period separately to confirm it keeps the old width. A stop is checked by counting the remaining high samples and then 64 samples of low output. A running monitor checks every completed phase for legal width.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;

    // Largest half-period is 2**MAX_SH fast cycles.
    localparam int MAX_SH = 3;
    localparam int SH_W   = 2;
    localparam int CNT_W  = MAX_SH;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_DIV8 = 2'b00,
        SEL_DIV4 = 2'b01,
        SEL_FULL = 2'b10,
        SEL_DIV2 = 2'b11
    } sel_e;

    typedef struct packed {
        logic            run;
        logic            level;
        logic [SH_W-1:0] rate;
    } ctrl_t;

endpackage

// File: rtl/ckdiv_rate_decode.sv
module ckdiv_rate_decode
    import ckdiv_pkg::*;
(
    input  logic [SEL_W-1:0] code,
    output logic [SH_W-1:0]  shift
);

    // Non-binary code: the order in which the pin pair steps through rates.
    always_comb begin
        unique case (sel_e'(code))
            SEL_DIV8: shift = SH_W'(3);
            SEL_DIV4: shift = SH_W'(2);
            SEL_DIV2: shift = SH_W'(1);
            SEL_FULL: shift = SH_W'(0);
            default:  shift = SH_W'(3);
        endcase
    end

endmodule

// File: rtl/ckdiv_half_timer.sv
module ckdiv_half_timer
    import ckdiv_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic [SH_W-1:0] shift,
    output logic            done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;

    // Half-period of 2**shift cycles; wraps to all ones for the largest.
    assign limit = (CNT_W'(1) << shift) - CNT_W'(1);
    assign done  = (cnt_q == limit);

    always_comb begin
        cnt_d = cnt_q + CNT_W'(1);
        if (restart || done) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/card_clk_divider.sv
module card_clk_divider
    import ckdiv_pkg::*;
#(
    parameter logic [SH_W-1:0] RESET_SH = SH_W'(MAX_SH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             run_en,
    output logic             card_clk
);

    ctrl_t           ctrl_d, ctrl_q;
    logic [SH_W-1:0] sel_shift;
    logic            phase_end;
    logic            timer_restart;

    ckdiv_rate_decode i_decode (
        .code  (rate_sel),
        .shift (sel_shift)
    );

    assign timer_restart = !ctrl_q.run;

    ckdiv_half_timer i_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (timer_restart),
        .shift   (ctrl_q.rate),
        .done    (phase_end)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (!ctrl_q.run) begin
            // Parked low: start with a full high phase at the selected rate.
            if (run_en) begin
                ctrl_d.run   = 1'b1;
                ctrl_d.level = 1'b1;
                ctrl_d.rate  = sel_shift;
            end
        end else if (phase_end) begin
            if (ctrl_q.level) begin
                ctrl_d.level = 1'b0;
            end else if (run_en) begin
                // Period boundary: the only point a new rate is taken.
                ctrl_d.level = 1'b1;
                ctrl_d.rate  = sel_shift;
            end else begin
                ctrl_d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.run   <= 1'b0;
            ctrl_q.level <= 1'b0;
            ctrl_q.rate  <= RESET_SH;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign card_clk = ctrl_q.level;

endmodule

// File: rtl/card_clk_divider_chk.sv
module card_clk_divider_chk
    import ckdiv_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            run_en,
    input logic            card_clk,
    input logic [SH_W-1:0] rate_sh
);

    logic [7:0] hi_cnt_q, lo_cnt_q;
    logic       seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt_q <= '0;
            lo_cnt_q <= '0;
            seen_q   <= 1'b0;
        end else begin
            hi_cnt_q <= card_clk ? hi_cnt_q + 8'd1 : 8'd0;
            lo_cnt_q <= card_clk ? 8'd0 : ((lo_cnt_q == 8'hff) ? lo_cnt_q : lo_cnt_q + 8'd1);
            seen_q   <= seen_q | ((hi_cnt_q != 8'd0) && !card_clk);
        end
    end

    // R9
    reset_low_chk: assert property (@(posedge clk) rst |=> !card_clk);

    // R9
    reset_rate_chk: assert property (@(posedge clk) rst |=> (rate_sh == SH_W'(MAX_SH)));

    // R7
    park_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !card_clk) |=> !card_clk);

    // R5
    rate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rate_sh) |-> $rose(card_clk));

    // R6
    hi_width_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(card_clk) && !$past(rst)) |-> (hi_cnt_q == (8'd1 << rate_sh)));

    // R6
    lo_width_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(card_clk) && seen_q) |-> (lo_cnt_q >= (8'd1 << $past(rate_sh))));

endmodule

bind card_clk_divider card_clk_divider_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .card_clk (card_clk),
    .rate_sh  (ctrl_q.rate)
);

// File: tb/test_card_clk_divider.sv
module test_card_clk_divider;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_en = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       card_clk;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    card_clk_divider i_card_clk_divider (
        .clk      (clk),
        .rst      (rst),
        .rate_sel (rate_sel),
        .run_en   (run_en),
        .card_clk (card_clk)
    );

    typedef struct packed {
        logic [1:0] code;
        logic [7:0] half;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{code: 2'b10, half: 8'd1},
        '{code: 2'b01, half: 8'd4},
        '{code: 2'b11, half: 8'd2},
        '{code: 2'b00, half: 8'd8},
        '{code: 2'b11, half: 8'd2},
        '{code: 2'b10, half: 8'd1},
        '{code: 2'b01, half: 8'd4}
    };

    function automatic string req_of(input logic [1:0] code);
        case (code)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b11:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_rise();
        logic prev;
        prev = card_clk;
        @(negedge clk);
        while (!(!prev && card_clk)) begin
            prev = card_clk;
            @(negedge clk);
        end
    endtask

    task automatic meas_high(output int n);
        n = 0;
        while (card_clk && n < 64) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic meas_low(output int n);
        n = 0;
        while (!card_clk && n < 64) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Phase-width monitor for R6
    int  mon_hi = 0;
    int  mon_lo = 0;
    int  last_hi = 0;
    bit  mon_seen = 0;
    bit  mon_prev = 0;

    always @(negedge clk) begin
        if (rst) begin
            mon_hi = 0; mon_lo = 0; mon_seen = 0; mon_prev = 0;
        end else begin
            if (card_clk) begin
                if (!mon_prev && mon_seen) begin
                    tests++;
                    if (mon_lo < last_hi) begin
                        fails++;
                        $display("FAIL R6: actual low %0d expected at least %0d", mon_lo, last_hi);
                    end
                end
                mon_hi = mon_prev ? mon_hi + 1 : 1;
            end else begin
                if (mon_prev) begin
                    last_hi  = mon_hi;
                    mon_seen = 1;
                    tests++;
                    if (!(mon_hi == 1 || mon_hi == 2 || mon_hi == 4 || mon_hi == 8)) begin
                        fails++;
                        $display("FAIL R6: actual high %0d expected 1, 2, 4 or 8", mon_hi);
                    end
                end
                mon_lo = mon_prev ? 1 : mon_lo + 1;
            end
            mon_prev = card_clk;
        end
    end

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int hi, lo;

        // R9: reset holds output low even with run requested
        run_en   = 1'b1;
        rate_sel = 2'b00;
        repeat (3) @(negedge clk);
        chk("R9", int'(card_clk), 0);
        @(negedge clk);
        chk("R9", int'(card_clk), 0);

        // R8: start one edge after release
        rst = 1'b0;
        @(negedge clk);
        chk("R8", int'(card_clk), 1);
        meas_high(hi);
        chk("R1", hi, 8);
        meas_low(lo);
        chk("R1", lo, 8);

        // Rate table
        for (int i = 0; i < 7; i++) begin
            rate_sel = VECS[i].code;
            wait_rise();
            meas_high(hi);
            chk(req_of(VECS[i].code), hi, int'(VECS[i].half));
            meas_low(lo);
            chk(req_of(VECS[i].code), lo, int'(VECS[i].half));
        end

        // R5: code change during a high phase waits for the boundary
        rate_sel = 2'b00;
        wait_rise();
        wait_rise();
        rate_sel = 2'b10;
        meas_high(hi);
        chk("R5", hi, 8);
        meas_low(lo);
        chk("R5", lo, 8);
        meas_high(hi);
        chk("R5", hi, 1);

        // R7: stop during a high phase completes it, then parks low
        rate_sel = 2'b01;
        wait_rise();
        wait_rise();
        run_en = 1'b0;
        meas_high(hi);
        chk("R7", hi, 4);
        meas_low(lo);
        chk("R7", lo, 64);

        // R8: restart from stop uses the code present at start
        run_en   = 1'b1;
        rate_sel = 2'b11;
        @(negedge clk);
        chk("R8", int'(card_clk), 1);
        meas_high(hi);
        chk("R8", hi, 2);

        // R7: stop during a low phase
        wait_rise();
        meas_high(hi);
        run_en = 1'b0;
        meas_low(lo);
        chk("R7", lo, 64);

        // R9: reset in the middle of a high phase
        run_en   = 1'b1;
        rate_sel = 2'b00;
        wait_rise();
        rst = 1'b1;
        @(negedge clk);
        chk("R9", int'(card_clk), 0);
        run_en = 1'b0;
        rst    = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9", int'(card_clk), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule